// File: doc/BRIEF.md
# Flash Identification Probe Sequencer

This block finds out which parallel NOR flash device sits on an 8-bit asynchronous bus. It does this by running the standard command-driven identification dialogue in hardware, so no processor has to run it. A one-cycle `start` pulse launches a probe. The sequencer first polls location zero until two reads in a row return the same byte, or until a configurable number of mismatching reads has passed; either outcome lets the probe go on. It then writes a reset command and the three-write unlock that switches the device into its identification mode. Next it reads the vendor byte and the device byte, and finally writes the reset command again so the array reads normally afterwards.

When the probe finishes, `done` pulses for one cycle. At the same moment `found` and the 16-bit identifier are loaded, and both hold their values until the next probe completes. A device counts as recognised only when both code bytes have odd parity. Bus timing is set by parameters: address and data setup before the write strobe, the strobe width, and the read access time.

Top module: `nor_id_probe`

## Requirements
- R1: While reset is low and in the first cycle after it rises, `mem_wr_en`, `mem_rd_en`, `done`, `busy` and `found` are 0 and `dev_id` is 0.
- R2: After `start` is accepted, the block reads address 0 repeatedly. It stops polling at the first read whose byte equals the read before it, or after SETTLE_LIMIT reads that each differed from their predecessor, so at most SETTLE_LIMIT+1 polling reads occur.
- R3: After polling, the block writes exactly four commands in this order: 0xF0 to 0x555, 0xAA to 0x555, 0x55 to 0x2AA, 0x90 to 0x555.
- R4: After the fourth command, the block reads the vendor byte from address 0 and then the device byte from address 1.
- R5: `dev_id[15:8]` holds the vendor byte and `dev_id[7:0]` holds the device byte.
- R6: `found` is 1 only when both bytes have an odd number of set bits; otherwise it is 0.
- R7: After the two reads, and whatever the parity outcome, the block writes 0xF0 to 0x555 before reporting completion.
- R8: Each write holds address and data for SETUP_CYC cycles with the write strobe low. It then raises `mem_wr_en` for exactly STROBE_CYC cycles with address and data stable, then spends one more cycle with the strobe low.
- R9: Each read raises `mem_rd_en` for exactly ACCESS_CYC cycles with a stable address and captures `mem_rdata` in the last of those cycles. The strobe then stays low for one cycle.
- R10: `busy` rises the cycle after an accepted `start`. Between bus operations the bus spends one cycle with both strobes low. `done` is high for one cycle, while `busy` is still high, right after the final write. `found` and `dev_id` change only in the `done` cycle. A `start` seen while `busy` is high has no effect.
- R11: `mem_wr_en` and `mem_rd_en` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a probe (accepted only when idle) |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Both code bytes had odd parity |
| dev_id | output | 16 | Vendor byte (upper) and device byte (lower) |
| mem_addr | output | ADDR_W | Flash address |
| mem_wdata | output | 8 | Flash write data |
| mem_rdata | input | 8 | Flash read data |
| mem_wr_en | output | 1 | Write strobe, active high |
| mem_rd_en | output | 1 | Read strobe, active high |

## Verification
On every cycle the assertions check several local rules: the strobes never overlap, and address and data stay put while a strobe is high. Each write and read strobe pulse must have its exact width, `done` must be a single-cycle pulse inside `busy`, and the reported result must not move outside `done` and must agree with the parity rule. Other behaviour can only be shown by the bench's scenarios, because it depends on the whole dialogue with a flash model. That covers the number of polling reads for stable, settling and never-settling data, the command order and its addresses and data, which address each code byte comes from, and the closing reset write on both the accepted and the rejected path.

// File: rtl/nor_id_pkg.sv
package nor_id_pkg;
   localparam logic [7:0] CMD_READ_ARRAY = 8'hF0;
   localparam logic [7:0] CMD_UNLOCK_A   = 8'hAA;
   localparam logic [7:0] CMD_UNLOCK_B   = 8'h55;
   localparam logic [7:0] CMD_ID_MODE    = 8'h90;

   localparam int unsigned ADR_CMD_PRI = 32'h555;
   localparam int unsigned ADR_CMD_SEC = 32'h2AA;
   localparam int unsigned ADR_VENDOR  = 32'h000;
   localparam int unsigned ADR_DEVICE  = 32'h001;

   typedef enum logic [3:0] {
      PS_IDLE,
      PS_POLL,
      PS_CMD_RST,
      PS_CMD_UA,
      PS_CMD_UB,
      PS_CMD_ID,
      PS_RD_VEN,
      PS_RD_DEV,
      PS_CMD_EXIT,
      PS_REPORT
   } probe_state_t;

   typedef enum logic [2:0] {
      BS_IDLE,
      BS_SETUP,
      BS_STROBE,
      BS_HOLD,
      BS_ACCESS,
      BS_RDONE
   } bus_state_t;
endpackage

// File: rtl/nor_bus_engine.sv
module nor_bus_engine
   import nor_id_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 8,
   parameter int SETUP_CYC  = 2,
   parameter int STROBE_CYC = 4,
   parameter int ACCESS_CYC = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_req,
   input  logic              op_write,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [DATA_W-1:0] op_wdata,
   output logic              op_ack,
   output logic [DATA_W-1:0] op_rdata,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              bus_wr,
   output logic              bus_rd
);
   localparam int MAX_A = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
   localparam int MAXC  = (MAX_A > ACCESS_CYC) ? MAX_A : ACCESS_CYC;
   localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;

   generate
      if (SETUP_CYC < 1 || STROBE_CYC < 1 || ACCESS_CYC < 1) begin : g_bad_timing
         $error("nor_bus_engine: every timing count must be at least 1");
      end
   endgenerate

   bus_state_t        st;
   logic [CNT_W-1:0]  cnt;
   logic [ADDR_W-1:0] lat_addr;
   logic [DATA_W-1:0] lat_wdata;
   logic [DATA_W-1:0] cap_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= BS_IDLE;
         cnt       <= '0;
         lat_addr  <= '0;
         lat_wdata <= '0;
         cap_q     <= '0;
      end else begin
         unique case (st)
            BS_IDLE: begin
               if (op_req) begin
                  lat_addr  <= op_addr;
                  lat_wdata <= op_wdata;
                  if (op_write) begin
                     st  <= BS_SETUP;
                     cnt <= CNT_W'(SETUP_CYC - 1);
                  end else begin
                     st  <= BS_ACCESS;
                     cnt <= CNT_W'(ACCESS_CYC - 1);
                  end
               end
            end
            BS_SETUP: begin
               if (cnt == '0) begin
                  st  <= BS_STROBE;
                  cnt <= CNT_W'(STROBE_CYC - 1);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            BS_STROBE: begin
               if (cnt == '0) st <= BS_HOLD;
               else           cnt <= cnt - 1'b1;
            end
            BS_HOLD: st <= BS_IDLE;
            BS_ACCESS: begin
               if (cnt == '0) begin
                  cap_q <= bus_rdata;
                  st    <= BS_RDONE;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            BS_RDONE: st <= BS_IDLE;
            default:  st <= BS_IDLE;
         endcase
      end
   end

   assign op_ack    = (st == BS_HOLD) || (st == BS_RDONE);
   assign op_rdata  = cap_q;
   assign bus_addr  = lat_addr;
   assign bus_wdata = lat_wdata;
   assign bus_wr    = (st == BS_STROBE);
   assign bus_rd    = (st == BS_ACCESS);
endmodule

// File: rtl/nor_settle_tracker.sv
module nor_settle_tracker #(
   parameter int DATA_W = 8,
   parameter int LIMIT  = 10000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              sample_vld,
   input  logic [DATA_W-1:0] sample,
   output logic              quiet
);
   localparam int MISS_W = $clog2(LIMIT + 1);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("nor_settle_tracker: LIMIT must be at least 1");
      end
   endgenerate

   logic              have_prev;
   logic [DATA_W-1:0] prev_q;
   logic [MISS_W-1:0] miss_q;
   logic              same;

   assign same  = (sample == prev_q);
   assign quiet = have_prev && (same || (miss_q == MISS_W'(LIMIT - 1)));

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         have_prev <= 1'b0;
         prev_q    <= '0;
         miss_q    <= '0;
      end else if (sample_vld) begin
         have_prev <= 1'b1;
         prev_q    <= sample;
         if (have_prev && !same) miss_q <= miss_q + 1'b1;
      end
   end
endmodule

// File: rtl/nor_odd_parity.sv
module nor_odd_parity #(
   parameter int W = 8
) (
   input  logic [W-1:0] data,
   output logic         odd
);
   logic [W:0] chain;
   assign chain[0] = 1'b0;
   generate
      for (genvar gi = 0; gi < W; gi++) begin : g_xor
         assign chain[gi+1] = chain[gi] ^ data[gi];
      end
   endgenerate
   assign odd = chain[W];
endmodule

// File: rtl/nor_id_probe.sv
module nor_id_probe
   import nor_id_pkg::*;
#(
   parameter int ADDR_W       = 12,
   parameter int DATA_W       = 8,
   parameter int SETUP_CYC    = 2,
   parameter int STROBE_CYC   = 4,
   parameter int ACCESS_CYC   = 3,
   parameter int SETTLE_LIMIT = 10000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   output logic                busy,
   output logic                done,
   output logic                found,
   output logic [2*DATA_W-1:0] dev_id,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [DATA_W-1:0]   mem_wdata,
   input  logic [DATA_W-1:0]   mem_rdata,
   output logic                mem_wr_en,
   output logic                mem_rd_en
);
   localparam int N_CODES = 2;

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("nor_id_probe: command bytes need DATA_W of 8");
      end
      if (ADDR_W < 11) begin : g_bad_addr
         $error("nor_id_probe: ADDR_W must reach the 0x555 command address");
      end
   endgenerate

   probe_state_t      ps;
   logic              op_req, op_write, op_ack;
   logic [ADDR_W-1:0] op_addr;
   logic [DATA_W-1:0] op_wdata, op_rdata;
   logic              quiet;
   logic [DATA_W-1:0] code_q [N_CODES];
   logic [N_CODES-1:0] code_odd;
   logic              found_q;
   logic [2*DATA_W-1:0] id_q;

   // Operation selection per state
   always_comb begin
      op_req   = 1'b1;
      op_write = 1'b1;
      op_addr  = ADDR_W'(ADR_CMD_PRI);
      op_wdata = CMD_READ_ARRAY;
      unique case (ps)
         PS_IDLE, PS_REPORT: op_req = 1'b0;
         PS_POLL: begin
            op_write = 1'b0;
            op_addr  = ADDR_W'(ADR_VENDOR);
         end
         PS_CMD_RST:  op_wdata = CMD_READ_ARRAY;
         PS_CMD_UA:   op_wdata = CMD_UNLOCK_A;
         PS_CMD_UB: begin
            op_addr  = ADDR_W'(ADR_CMD_SEC);
            op_wdata = CMD_UNLOCK_B;
         end
         PS_CMD_ID:   op_wdata = CMD_ID_MODE;
         PS_RD_VEN: begin
            op_write = 1'b0;
            op_addr  = ADDR_W'(ADR_VENDOR);
         end
         PS_RD_DEV: begin
            op_write = 1'b0;
            op_addr  = ADDR_W'(ADR_DEVICE);
         end
         PS_CMD_EXIT: op_wdata = CMD_READ_ARRAY;
         default:     op_req = 1'b0;
      endcase
   end

   nor_bus_engine #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETUP_CYC(SETUP_CYC),
      .STROBE_CYC(STROBE_CYC), .ACCESS_CYC(ACCESS_CYC)
   ) u_bus (
      .clk(clk), .rst_n(rst_n),
      .op_req(op_req), .op_write(op_write), .op_addr(op_addr), .op_wdata(op_wdata),
      .op_ack(op_ack), .op_rdata(op_rdata),
      .bus_addr(mem_addr), .bus_wdata(mem_wdata), .bus_rdata(mem_rdata),
      .bus_wr(mem_wr_en), .bus_rd(mem_rd_en)
   );

   nor_settle_tracker #(.DATA_W(DATA_W), .LIMIT(SETTLE_LIMIT)) u_settle (
      .clk(clk), .rst_n(rst_n),
      .clear(ps == PS_IDLE && start),
      .sample_vld(op_ack && ps == PS_POLL),
      .sample(op_rdata),
      .quiet(quiet)
   );

   generate
      for (genvar gc = 0; gc < N_CODES; gc++) begin : g_par
         nor_odd_parity #(.W(DATA_W)) u_par (.data(code_q[gc]), .odd(code_odd[gc]));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ps      <= PS_IDLE;
         found_q <= 1'b0;
         id_q    <= '0;
         for (int i = 0; i < N_CODES; i++) code_q[i] <= '0;
      end else begin
         unique case (ps)
            PS_IDLE:     if (start) ps <= PS_POLL;
            PS_POLL:     if (op_ack && quiet) ps <= PS_CMD_RST;
            PS_CMD_RST:  if (op_ack) ps <= PS_CMD_UA;
            PS_CMD_UA:   if (op_ack) ps <= PS_CMD_UB;
            PS_CMD_UB:   if (op_ack) ps <= PS_CMD_ID;
            PS_CMD_ID:   if (op_ack) ps <= PS_RD_VEN;
            PS_RD_VEN: if (op_ack) begin
               code_q[0] <= op_rdata;
               ps        <= PS_RD_DEV;
            end
            PS_RD_DEV: if (op_ack) begin
               code_q[1] <= op_rdata;
               ps        <= PS_CMD_EXIT;
            end
            PS_CMD_EXIT: if (op_ack) begin
               found_q <= &code_odd;
               id_q    <= {code_q[0], code_q[1]};
               ps      <= PS_REPORT;
            end
            PS_REPORT:   ps <= PS_IDLE;
            default:     ps <= PS_IDLE;
         endcase
      end
   end

   assign busy   = (ps != PS_IDLE);
   assign done   = (ps == PS_REPORT);
   assign found  = found_q;
   assign dev_id = id_q;
endmodule

// File: rtl/nor_id_probe_chk.sv
module nor_id_probe_chk #(
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 8,
   parameter int STROBE_CYC = 4,
   parameter int ACCESS_CYC = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                busy,
   input logic                done,
   input logic                found,
   input logic [2*DATA_W-1:0] dev_id,
   input logic [ADDR_W-1:0]   mem_addr,
   input logic [DATA_W-1:0]   mem_wdata,
   input logic                mem_wr_en,
   input logic                mem_rd_en
);
   int wr_run, rd_run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_run <= 0;
         rd_run <= 0;
      end else begin
         wr_run <= mem_wr_en ? wr_run + 1 : 0;
         rd_run <= mem_rd_en ? rd_run + 1 : 0;
      end
   end

   a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_wr_en && mem_rd_en));

   a_r8_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_en && $past(mem_wr_en)) |-> ($stable(mem_addr) && $stable(mem_wdata)));

   a_r8_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_wr_en) |-> (wr_run == STROBE_CYC));

   a_r9_read_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && $past(mem_rd_en)) |-> $stable(mem_addr));

   a_r9_access_width: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_rd_en) |-> (rd_run == ACCESS_CYC));

   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(found) && $stable(dev_id)));

   a_r6_found_parity: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (found == ((^dev_id[2*DATA_W-1:DATA_W]) && (^dev_id[DATA_W-1:0]))));
endmodule

bind nor_id_probe nor_id_probe_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STROBE_CYC(STROBE_CYC), .ACCESS_CYC(ACCESS_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .found(found), .dev_id(dev_id),
   .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en)
);

// File: tb/sim_nor_id_probe.sv
`timescale 1ns/1ps
module sim_nor_id_probe;
   localparam int AW = 12, DW = 8, SU = 2, ST = 3, AC = 2, LIM = 6;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n = 1'b0, start = 1'b0;
   logic busy, done, found, mem_wr_en, mem_rd_en;
   logic [15:0] dev_id;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;

   nor_id_probe #(.ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(SU), .STROBE_CYC(ST),
                  .ACCESS_CYC(AC), .SETTLE_LIMIT(LIM)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .found(found), .dev_id(dev_id), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en));

   typedef struct packed {
      logic wr, rd, dn, bz, fnd;
      logic [AW-1:0] addr;
      logic [DW-1:0] wd;
      logic [15:0] id;
   } exp_t;

   exp_t  expq[$];
   string tagq[$];
   int    n_chk = 0, n_fail = 0;
   logic  cur_found = 1'b0;
   logic [15:0] cur_id = '0;
   logic  mon_en = 1'b0;

   // behavioural flash model
   logic [7:0] base_vals[$];
   int   base_idx = 0;
   logic [7:0] fl_ven = '0, fl_dev = '0;
   logic fl_auto = 1'b0;
   int   unl_step = 0;
   logic prev_wr = 1'b0, prev_rd = 1'b0;

   always @(negedge clk) begin
      if (mem_wr_en && !prev_wr) begin
         if (mem_wdata == 8'hF0) begin fl_auto = 1'b0; unl_step = 0; end
         else if (unl_step == 0 && mem_wdata == 8'hAA && mem_addr == 12'h555) unl_step = 1;
         else if (unl_step == 1 && mem_wdata == 8'h55 && mem_addr == 12'h2AA) unl_step = 2;
         else if (unl_step == 2 && mem_wdata == 8'h90 && mem_addr == 12'h555) begin
            fl_auto = 1'b1; unl_step = 0;
         end else unl_step = 0;
      end
      if (!mem_rd_en && prev_rd && !fl_auto) base_idx++;
      if (fl_auto) mem_rdata = (mem_addr == 12'h000) ? fl_ven : (mem_addr == 12'h001) ? fl_dev : 8'h00;
      else if (base_vals.size() == 0) mem_rdata = 8'h00;
      else mem_rdata = base_vals[(base_idx < base_vals.size()) ? base_idx : base_vals.size() - 1];
      prev_wr = mem_wr_en;
      prev_rd = mem_rd_en;
   end

   // cycle-by-cycle comparison against the expected stream
   always @(negedge clk) begin
      if (mon_en) begin
         exp_t e;
         string t;
         logic ok;
         if (expq.size() > 0) begin
            e = expq.pop_front();
            t = tagq.pop_front();
         end else begin
            e = '0;
            t = "R10";
         end
         if (e.dn) begin cur_found = e.fnd; cur_id = e.id; end
         ok = (mem_wr_en == e.wr) && (mem_rd_en == e.rd) && (done == e.dn) && (busy == e.bz)
              && (found == cur_found) && (dev_id == cur_id)
              && (!e.wr || (mem_addr == e.addr && mem_wdata == e.wd))
              && (!e.rd || mem_addr == e.addr) && !(mem_wr_en && mem_rd_en);
         n_chk++;
         if (!ok) begin
            n_fail++;
            $display("FAIL %s (R11 overlap=%b) cycle: got wr=%b rd=%b addr=%h wd=%h done=%b busy=%b found=%b id=%h, expected wr=%b rd=%b addr=%h wd=%h done=%b busy=%b found=%b id=%h",
                     t, mem_wr_en && mem_rd_en, mem_wr_en, mem_rd_en, mem_addr, mem_wdata, done, busy,
                     found, dev_id, e.wr, e.rd, e.addr, e.wd, e.dn, e.bz, cur_found, cur_id);
         end
      end
   end

   task automatic push(input exp_t e, input string t);
      expq.push_back(e);
      tagq.push_back(t);
   endtask

   task automatic push_gap(input string t);
      exp_t e = '0;
      e.bz = 1'b1;
      push(e, t);
   endtask

   // R8: gap, SU setup cycles, ST strobe cycles, one hold cycle
   task automatic push_wr(input logic [AW-1:0] a, input logic [7:0] d, input string t);
      exp_t e = '0;
      push_gap("R10");
      for (int i = 0; i < SU; i++) push_gap("R8");
      e.bz = 1'b1; e.wr = 1'b1; e.addr = a; e.wd = d;
      for (int i = 0; i < ST; i++) push(e, t);
      push_gap("R8");
   endtask

   // R9: gap, AC strobe cycles, one cycle low
   task automatic push_rd(input logic [AW-1:0] a, input string t);
      exp_t e = '0;
      push_gap("R10");
      e.bz = 1'b1; e.rd = 1'b1; e.addr = a;
      for (int i = 0; i < AC; i++) push(e, t);
      push_gap("R9");
   endtask

   function automatic int poll_reads(input logic [7:0] v[$]);
      int k = 1, misses = 0;
      forever begin
         logic [7:0] a, b;
         a = v[(k < v.size()) ? k : v.size() - 1];
         b = v[(k - 1 < v.size()) ? k - 1 : v.size() - 1];
         k++;
         if (a == b) break;
         misses++;
         if (misses == LIM) break;
      end
      return k;
   endfunction

   task automatic check(input logic cond, input string t, input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (!cond) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", t, act, expv);
      end
   endtask

   task automatic run_probe(input logic [7:0] vals[$], input logic [7:0] ven, input logic [7:0] dv,
                            input int poke_at);
      exp_t e;
      int   n;
      logic f;
      @(posedge clk); #1;
      base_vals = vals; base_idx = 0; fl_ven = ven; fl_dev = dv;
      f = (^ven) && (^dv);
      n = poll_reads(vals);
      start = 1'b1;
      e = '0;
      push(e, "R10");
      for (int i = 0; i < n; i++) push_rd(12'h000, "R2");
      push_wr(12'h555, 8'hF0, "R3");
      push_wr(12'h555, 8'hAA, "R3");
      push_wr(12'h2AA, 8'h55, "R3");
      push_wr(12'h555, 8'h90, "R3");
      push_rd(12'h000, "R4");
      push_rd(12'h001, "R4");
      push_wr(12'h555, 8'hF0, "R7");
      e = '0; e.dn = 1'b1; e.bz = 1'b1; e.fnd = f; e.id = {ven, dv};
      push(e, "R10");
      @(posedge clk); #1;
      start = 1'b0;
      for (int c = 0; expq.size() > 0; c++) begin
         @(posedge clk); #1;
         start = (c == poke_at);
      end
      start = 1'b0;
      repeat (4) @(posedge clk);
      #1;
      check(dev_id == {ven, dv}, "R5 identifier", 32'(dev_id), 32'({ven, dv}));
      check(found == f, "R6 found", 32'(found), 32'(f));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog: got busy=%b expected run to finish", busy);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] v[$];
      repeat (3) @(posedge clk);
      #1;
      check({mem_wr_en, mem_rd_en, done, busy, found} == 5'b0 && dev_id == 16'h0, "R1 reset outputs",
            32'({mem_wr_en, mem_rd_en, done, busy, found, dev_id}), 32'h0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      mon_en = 1'b1;
      // R2 stable at once; R6 accepted codes
      v = '{8'h3C, 8'h3C};
      run_probe(v, 8'h20, 8'hE3, -1);
      // R2 settles after several mismatches
      v = '{8'h40, 8'h00, 8'h40, 8'h40};
      run_probe(v, 8'h1F, 8'h8C, -1);
      // R2 never settles: gives up after LIM mismatches
      v = '{8'h80, 8'h00, 8'h80, 8'h00, 8'h80, 8'h00, 8'h80, 8'h00, 8'h80, 8'h00};
      run_probe(v, 8'h01, 8'h02, -1);
      // R6 even vendor parity rejected, R7 exit still written
      v = '{8'h11, 8'h11};
      run_probe(v, 8'h03, 8'h01, -1);
      // R6 even device parity rejected
      v = '{8'h22, 8'h22};
      run_probe(v, 8'h01, 8'h00, -1);
      // R10 start while busy has no effect
      v = '{8'h05, 8'h07, 8'h07};
      run_probe(v, 8'h07, 8'hB0, 20);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule